// File: doc/BRIEF.md
# Shared Ready/Data Serial Output Pin Controller

This block drives one output pin that has two jobs. When a new 24-bit conversion result arrives on a one-cycle strobe, the pin runs a fixed-length ready phase: it is held high, then pulled low for a pulse, then held high again. That pulse tells a host that a fresh word is waiting. After the ready phase the pin switches to data mode. It shows the most significant bit of the stored word, and each rising edge of an external serial clock moves the next bit onto the pin.

The serial clock is asynchronous to the system clock. It passes through a two-stage synchroniser and an edge detector before it can shift the output register. A new strobe always takes priority. It reloads the register, drops any bits that were not read, and starts a new ready phase.

Results taken just after power-up cannot be trusted, so the block counts ready pulses. A status output goes high at the start of the sixth low pulse after reset and stays high after that.

Top module: `rdy_data_pin`

## Requirements
- R1: While reset is asserted and after reset until the first strobe, `pin_o` is 1 and `data_valid_o` is 0.
- R2: A strobe sampled at clock edge E0 starts a ready phase. Counting k clock edges after E0 (k = 0 is the interval right after E0), `pin_o` is 1 for k = 0..11, 0 for k = 12..23 and 1 for k = 24..35.
- R3: From k = 36 on, the block is in data mode and `pin_o` equals bit 23 (the MSB) of the word captured with the strobe.
- R4: In data mode, each rising edge of `sclk_i` moves the next lower bit onto `pin_o`, MSB first. After the n-th edge the pin shows bit 23-n. After 24 or more edges the pin shows 0.
- R5: Rising edges of `sclk_i` that occur during a ready phase have no effect. On entry to data mode the pin still shows bit 23.
- R6: With no edges on `sclk_i`, the pin stays in data mode on its current bit for as long as no new strobe arrives.
- R7: A strobe during data mode discards the unread bits, captures the new word and restarts the ready phase timing of R2.
- R8: A strobe during a ready phase restarts the timing of R2 from k = 0 and captures the new word.
- R9: `data_valid_o` rises at the start (k = 12) of the sixth low pulse after reset and stays 1 until the next reset.
- R10: A ready phase cut short by a strobe before its low pulse starts does not count toward the six pulses of R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| result_i | input | 24 | Conversion result, captured when the strobe is high |
| result_stb_i | input | 1 | One-cycle strobe that marks a new result |
| sclk_i | input | 1 | External serial clock, asynchronous |
| pin_o | output | 1 | Shared ready-pulse / serial data pin |
| data_valid_o | output | 1 | High once the sixth ready pulse has started |

## Verification
The bench checks the ready window cycle by cycle.

- An off-by-one in the phase timer would shift the low pulse or cut the ready phase short.
- Serial clock edges are sent during the ready phase. A design that lets them through would reach data mode with the MSB already shifted away.
- Strobes arrive part way through the data phase and part way through the ready phase. A design that did not reload or restart would go on showing stale bits, or would end its low pulse at the old time.
- The start-up count is checked on the exact cycle the sixth pulse begins, and after an aborted phase. A design that counted strobes instead of pulses would raise the valid flag one phase early.

// File: rtl/pin_ctrl_pkg.sv
package pin_ctrl_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READY = 2'd1,
    PH_DATA  = 2'd2
  } phase_e;
endpackage

// File: rtl/sclk_edge_sync.sv
module sclk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], sclk_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  assert_rise_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ready_seq.sv
module ready_seq
  import pin_ctrl_pkg::*;
#(
  parameter int HI_PRE  = 12,
  parameter int LO_LEN  = 12,
  parameter int HI_POST = 12
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  output phase_e phase_o,
  output logic   ready_lvl_o,
  output logic   pulse_start_o
);
  localparam int READY_LEN = HI_PRE + LO_LEN + HI_POST;
  localparam int TMR_W     = $clog2(READY_LEN);
  localparam logic [TMR_W-1:0] LAST_T = TMR_W'(READY_LEN - 1);
  localparam logic [TMR_W-1:0] LO_BEG = TMR_W'(HI_PRE);
  localparam logic [TMR_W-1:0] LO_END = TMR_W'(HI_PRE + LO_LEN);
  localparam logic [TMR_W-1:0] PRE_T  = TMR_W'(HI_PRE - 1);

  phase_e           phase_q;
  logic [TMR_W-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      tmr_q   <= '0;
    end else if (load_i) begin
      phase_q <= PH_READY;
      tmr_q   <= '0;
    end else if (phase_q == PH_READY) begin
      if (tmr_q == LAST_T) begin
        phase_q <= PH_DATA;
        tmr_q   <= '0;
      end else begin
        tmr_q <= tmr_q + 1'b1;
      end
    end
  end

  assign phase_o       = phase_q;
  assign ready_lvl_o   = !((tmr_q >= LO_BEG) && (tmr_q < LO_END));
  // counted on the edge that enters the low window; a restart cancels it
  assign pulse_start_o = (phase_q == PH_READY) && (tmr_q == PRE_T) && !load_i;

  assert_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (phase_q == PH_READY) && (tmr_q == '0));
  assert_timer_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_q <= LAST_T);
  assert_data_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase_q == PH_DATA) |-> $past(tmr_q) == LAST_T);
endmodule

// File: rtl/dor_shift.sv
module dor_shift #(
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  output logic              msb_o
);
  logic [DATA_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= data_i;
    else if (shift_i) sr_q <= {sr_q[DATA_W-2:0], 1'b0};
  end

  assign msb_o = sr_q[DATA_W-1];

  assert_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> msb_o == $past(data_i[DATA_W-1]));
  assert_shift_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |=> msb_o == $past(sr_q[DATA_W-2]));
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && !load_i) |=> $stable(sr_q));
endmodule

// File: rtl/valid_track.sv
module valid_track #(
  parameter int VALID_AT = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic valid_o
);
  localparam int CNT_W = $clog2(VALID_AT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(VALID_AT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (pulse_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign valid_o = (cnt_q == CNT_MAX);

  assert_valid_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);
  assert_count_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_i |=> $stable(cnt_q));
endmodule

// File: rtl/rdy_data_pin.sv
module rdy_data_pin
  import pin_ctrl_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int HI_PRE   = 12,
  parameter int LO_LEN   = 12,
  parameter int HI_POST  = 12,
  parameter int VALID_AT = 6,
  parameter int SYNC_ST  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] result_i,
  input  logic              result_stb_i,
  input  logic              sclk_i,
  output logic              pin_o,
  output logic              data_valid_o
);
  phase_e phase;
  logic   ready_lvl, pulse_start, sclk_rise, dor_msb, shift_en;

  sclk_edge_sync #(.STAGES(SYNC_ST)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .rise_o (sclk_rise)
  );

  ready_seq #(.HI_PRE(HI_PRE), .LO_LEN(LO_LEN), .HI_POST(HI_POST)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .load_i        (result_stb_i),
    .phase_o       (phase),
    .ready_lvl_o   (ready_lvl),
    .pulse_start_o (pulse_start)
  );

  assign shift_en = sclk_rise && (phase == PH_DATA);

  dor_shift #(.DATA_W(DATA_W)) u_dor (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (result_stb_i),
    .data_i  (result_i),
    .shift_i (shift_en),
    .msb_o   (dor_msb)
  );

  valid_track #(.VALID_AT(VALID_AT)) u_valid (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pulse_i (pulse_start),
    .valid_o (data_valid_o)
  );

  always_comb begin
    unique case (phase)
      PH_READY: pin_o = ready_lvl;
      PH_DATA:  pin_o = dor_msb;
      default:  pin_o = 1'b1;
    endcase
  end

  assert_ready_ignores_sclk_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_READY && sclk_rise && !result_stb_i) |=> $stable(dor_msb));
  assert_idle_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_IDLE) |-> (pin_o && !data_valid_o));
endmodule

// File: tb/rdy_data_pin_test.sv
module rdy_data_pin_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] res = '0;
  logic        stb = 1'b0;
  logic        sclk = 1'b0;
  logic        pin, dvalid;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  rdy_data_pin uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .result_i     (res),
    .result_stb_i (stb),
    .sclk_i       (sclk),
    .pin_o        (pin),
    .data_valid_o (dvalid)
  );

  task automatic chk(input int got, input int exp, input string tag);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sclk  = 1'b0;
    stb   = 1'b0;
    repeat (3) @(negedge clk);
    chk(pin, 1, "R1 pin in reset");
    chk(dvalid, 0, "R1 valid in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // returns at the negedge right after the capturing edge (k = 0)
  task automatic strobe(input logic [23:0] w);
    res = w;
    stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
  endtask

  task automatic sclk_pulse();
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic int ready_exp(input int k);
    return (k >= 12 && k < 24) ? 0 : 1;
  endfunction

  task automatic t_reset();
    do_reset();
    chk(pin, 1, "R1 pin idle after reset");
    chk(dvalid, 0, "R1 valid idle after reset");
  endtask

  task automatic t_ready_and_shift(input logic [23:0] w);
    int bad = 0;
    strobe(w);
    for (int k = 0; k < 36; k++) begin
      if (pin !== ready_exp(k)) begin
        bad++;
        $display("FAIL R2: k=%0d pin %0d expected %0d", k, pin, ready_exp(k));
      end
      @(negedge clk);
    end
    n_chk++;
    if (bad != 0) n_fail++;
    chk(pin, w[23], "R3 MSB on data entry");
    for (int n = 1; n <= 26; n++) begin
      sclk_pulse();
      chk(pin, (n < 24) ? int'(w[23-n]) : 0, $sformatf("R4 bit after edge %0d", n));
    end
  endtask

  task automatic t_sclk_in_ready();
    logic [23:0] w = 24'hA5_3C_96;
    strobe(w);
    for (int i = 0; i < 3; i++) sclk_pulse();   // 24 cycles, still ready
    repeat (12) @(negedge clk);
    chk(pin, w[23], "R5 MSB kept despite edges in ready");
    sclk_pulse();
    chk(pin, w[22], "R5 first data edge gives bit 22");
  endtask

  task automatic t_hold();
    logic [23:0] w = 24'h7F_FF_FF;
    strobe(w);
    repeat (36) @(negedge clk);
    chk(pin, 0, "R6 MSB at data entry");
    repeat (500) @(negedge clk);
    chk(pin, 0, "R6 MSB held without sclk");
    sclk_pulse();
    chk(pin, 1, "R6 next bit after late edge");
  endtask

  task automatic t_restart_data();
    logic [23:0] w1 = 24'hFF_00_FF;
    logic [23:0] w2 = 24'h40_00_00;
    strobe(w1);
    repeat (36) @(negedge clk);
    sclk_pulse();
    sclk_pulse();
    chk(pin, 1, "R7 old word bit 21");
    strobe(w2);
    chk(pin, 1, "R7 restart k=0 high");
    repeat (12) @(negedge clk);
    chk(pin, 0, "R7 restart low at k=12");
    repeat (24) @(negedge clk);
    chk(pin, 0, "R7 new MSB");
    sclk_pulse();
    chk(pin, 1, "R7 new bit 22, unread bits dropped");
  endtask

  task automatic t_restart_ready();
    logic [23:0] w2 = 24'h80_00_01;
    strobe(24'h00_00_00);
    repeat (15) @(negedge clk);
    chk(pin, 0, "R8 inside first low pulse");
    strobe(w2);
    repeat (11) @(negedge clk);
    chk(pin, 1, "R8 high at new k=11");
    @(negedge clk);
    chk(pin, 0, "R8 low at new k=12");
    repeat (12) @(negedge clk);
    chk(pin, 1, "R8 high at new k=24");
    repeat (12) @(negedge clk);
    chk(pin, 1, "R8 new MSB at k=36");
  endtask

  task automatic t_valid_count();
    do_reset();
    for (int p = 1; p <= 5; p++) begin
      strobe(24'h123456 + 24'(p));
      repeat (36) @(negedge clk);
      chk(dvalid, 0, $sformatf("R9 low after pulse %0d", p));
    end
    strobe(24'h0F0F0F);
    repeat (5) @(negedge clk);
    strobe(24'hF0F0F0);            // aborted phase above must not count
    repeat (11) @(negedge clk);
    chk(dvalid, 0, "R10 low at k=11 of sixth pulse");
    @(negedge clk);
    chk(dvalid, 1, "R9 high at k=12 of sixth pulse");
    repeat (30) @(negedge clk);
    strobe(24'h000001);
    repeat (40) @(negedge clk);
    chk(dvalid, 1, "R9 stays high");
  endtask

  initial begin
    t_reset();
    t_ready_and_shift(24'hC3_5A_81);
    t_ready_and_shift(24'h12_34_5F);
    t_sclk_in_ready();
    t_hold();
    t_restart_data();
    t_restart_ready();
    t_valid_count();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule